// File: doc/BRIEF.md
# Load Fence Issue Controller

This block sits between instruction decode and execute in an in-order-issue pipeline whose operations may finish out of order. Each decoded instruction is offered on a valid/ready handshake. The block inspects the two opcode bytes, the ModRM byte, a lock-prefix flag and a feature-enable input to decide whether the instruction is a load fence.

A legal fence puts the block into a holding state. While holding, it keeps `dec_ready_o` low, so younger instructions can be fetched and queued upstream but cannot issue. It releases the hold once every older operation has signalled local completion. Older operations are tracked by a saturating counter. Issue pulses raise the counter and local-completion pulses lower it. Completion is local only: a store that has left the pipeline but still sits in the store buffer does not delay the fence. An illegal fence, meaning one with a lock prefix or one arriving while the feature is disabled, produces an invalid-opcode pulse and does not fence.

Speculative cache-fill requests travel through the block on a combinational path and are never ordered by a fence.

Top module: `fence_issue_ctl`

## Requirements
- R1: An instruction is a fence when `opc0_i` is 0x0F, `opc1_i` is 0xAE and ModRM bits [5:3] equal 5. When it is accepted with `lock_i` low and `feat_en_i` high, `dec_ready_o` is low on the following cycle.
- R2: A fence accepted with `lock_i` high raises `ud_o` for exactly one cycle, starting on the cycle after acceptance. It does not enter the holding state.
- R3: A fence accepted with `feat_en_i` low raises `ud_o` for one cycle, starting on the cycle after acceptance. It does not enter the holding state.
- R4: Any other byte combination is accepted as an ordinary instruction. This includes ModRM reg values 4 and 6 and a second opcode byte of 0xAF. Such an instruction raises neither `ud_o` nor the hold.
- R5: `retire_o` never rises while an older operation has issued without a matching local-completion pulse. The in-flight count changes by +1 on `op_issue_i` alone, by -1 on `op_done_i` alone, and not at all when both arrive together.
- R6: `retire_o` is a one-cycle pulse. It rises on the cycle after a holding state has seen a zero in-flight count, and `dec_ready_o` returns high in that same cycle.
- R7: While holding, `dec_ready_o` stays low even if a younger instruction is presented on `dec_valid_i`. That instruction stays pending and is accepted after the fence retires.
- R8: `fill_req_o` and `fill_addr_o` equal `fill_req_i` and `fill_addr_i` in every cycle, whether or not a fence is held.
- R9: `cnt_err_o` pulses for one cycle after a completion pulse arrives at a count of zero, or after an issue pulse arrives at the maximum count of 2^CNT_W-1. In both cases the count holds its value.
- R10: A second fence presented while a first is held is accepted only after the first has pulsed `retire_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid_i | input | 1 | Decoded instruction offered |
| dec_ready_o | output | 1 | Instruction may issue this cycle |
| opc0_i | input | 8 | First opcode byte |
| opc1_i | input | 8 | Second opcode byte |
| modrm_i | input | 8 | ModRM byte |
| lock_i | input | 1 | Lock prefix present |
| feat_en_i | input | 1 | Fence instruction enabled |
| op_issue_i | input | 1 | One operation issued to execute |
| op_done_i | input | 1 | One operation completed locally |
| fill_req_i | input | 1 | Speculative fill request in |
| fill_addr_i | input | FILL_W | Speculative fill address in |
| fill_req_o | output | 1 | Speculative fill request out |
| fill_addr_o | output | FILL_W | Speculative fill address out |
| ud_o | output | 1 | Invalid-opcode exception pulse |
| retire_o | output | 1 | Fence retire pulse |
| cnt_err_o | output | 1 | In-flight counter underflow or overflow |

## Verification
The fence is exercised in four situations, and each one separates a different possible fault:
- With nothing in flight, the test shows that the release takes a single cycle.
- With three operations outstanding, the retire cycle must follow the last completion pulse, and a younger instruction is held at the handshake the whole time.
- With the counter saturated, overflow handling and the full-count drain are both checked.
- Two fences back to back confirm that a fence is not accepted while another is held.

The encoding probes use a lock prefix, a disabled feature, ModRM reg values 4 and 6, and a wrong second byte. Together they separate the three outcomes: exception, fence, and ordinary issue. Fill traffic toggles throughout, including while a fence is held.

// File: rtl/fence_issue_ctl.sv
`timescale 1ns/1ps
module fence_issue_ctl #(
  parameter int CNT_W  = 4,
  parameter int FILL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid_i,
  output logic              dec_ready_o,
  input  logic [7:0]        opc0_i,
  input  logic [7:0]        opc1_i,
  input  logic [7:0]        modrm_i,
  input  logic              lock_i,
  input  logic              feat_en_i,
  input  logic              op_issue_i,
  input  logic              op_done_i,
  input  logic              fill_req_i,
  input  logic [FILL_W-1:0] fill_addr_i,
  output logic              fill_req_o,
  output logic [FILL_W-1:0] fill_addr_o,
  output logic              ud_o,
  output logic              retire_o,
  output logic              cnt_err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic fence_q, ud_q, ret_q, err_q;

  wire hit     = (opc0_i == 8'h0F) && (opc1_i == 8'hAE) && (modrm_i[5:3] == 3'd5);
  wire take    = dec_valid_i && dec_ready_o;
  wire illegal = lock_i || !feat_en_i;
  wire inc     = op_issue_i && !op_done_i;
  wire dec     = op_done_i && !op_issue_i;
  wire under   = dec && (cnt_q == '0);
  wire over    = inc && (cnt_q == CNT_MAX);
  wire drained = fence_q && (cnt_q == '0);

  assign dec_ready_o = !fence_q;
  assign fill_req_o  = fill_req_i;
  assign fill_addr_o = fill_addr_i;
  assign ud_o        = ud_q;
  assign retire_o    = ret_q;
  assign cnt_err_o   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fence_q <= 1'b0;
      ud_q    <= 1'b0;
      ret_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (inc && !over)      cnt_q <= cnt_q + 1'b1;
      else if (dec && !under) cnt_q <= cnt_q - 1'b1;
      err_q <= under || over;
      ud_q  <= take && hit && illegal;
      ret_q <= drained;
      if (drained)                      fence_q <= 1'b0;
      else if (take && hit && !illegal) fence_q <= 1'b1;
    end
  end
endmodule

module fence_issue_ctl_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid_i,
  input logic             dec_ready_o,
  input logic [7:0]       opc0_i,
  input logic [7:0]       opc1_i,
  input logic [7:0]       modrm_i,
  input logic             lock_i,
  input logic             feat_en_i,
  input logic             ud_o,
  input logic             retire_o,
  input logic [CNT_W-1:0] cnt_q
);
  logic is_fence, acc;
  assign is_fence = (opc0_i == 8'h0F) && (opc1_i == 8'hAE) && (modrm_i[5:3] == 3'd5);
  assign acc      = dec_valid_i && dec_ready_o && is_fence;

  // R1
  fence_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !lock_i && feat_en_i |=> !dec_ready_o);
  // R2
  lock_ud_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && lock_i |=> ud_o && dec_ready_o);
  // R3
  feat_ud_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !feat_en_i |=> ud_o && dec_ready_o);
  // R5
  drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_o |-> $past(cnt_q) == '0);
  // R6
  retire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_o |=> !retire_o);
  // R6
  ready_on_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_o |-> dec_ready_o);
  // R7
  hold_until_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_ready_o |=> dec_ready_o == retire_o);
endmodule

bind fence_issue_ctl fence_issue_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid_i), .dec_ready_o(dec_ready_o),
  .opc0_i(opc0_i), .opc1_i(opc1_i), .modrm_i(modrm_i), .lock_i(lock_i),
  .feat_en_i(feat_en_i), .ud_o(ud_o), .retire_o(retire_o), .cnt_q(cnt_q)
);

// File: tb/fence_issue_ctl_test.sv
`timescale 1ns/1ps
module fence_issue_ctl_test;
  localparam int CNT_W  = 4;
  localparam int FILL_W = 32;
  localparam int MAXC   = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic dec_valid = 0, lock = 0, feat = 1, iss = 0, done = 0, freq = 0;
  logic [7:0] o0 = 0, o1 = 0, mr = 0;
  logic [FILL_W-1:0] faddr = 0;
  logic rdy, ud, ret, err, freq_o;
  logic [FILL_W-1:0] faddr_o;

  fence_issue_ctl #(.CNT_W(CNT_W), .FILL_W(FILL_W)) uut (
    .clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid), .dec_ready_o(rdy),
    .opc0_i(o0), .opc1_i(o1), .modrm_i(mr), .lock_i(lock), .feat_en_i(feat),
    .op_issue_i(iss), .op_done_i(done), .fill_req_i(freq), .fill_addr_i(faddr),
    .fill_req_o(freq_o), .fill_addr_o(faddr_o), .ud_o(ud), .retire_o(ret),
    .cnt_err_o(err));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, n_ret = 0;
  string phase = "R1";
  bit cmp_on = 0, finished = 0;
  int m_cnt = 0;
  bit m_fence = 0, m_ud = 0, m_ret = 0, m_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_fence = 0; m_ud = 0; m_ret = 0; m_err = 0;
    end else begin
      bit acc, hit, bad, drained;
      acc = dec_valid && !m_fence;
      hit = (o0 == 8'h0F) && (o1 == 8'hAE) && (mr[5:3] == 3'd5);
      bad = lock || !feat;
      drained = m_fence && (m_cnt == 0);
      m_err = (done && !iss && m_cnt == 0) || (iss && !done && m_cnt == MAXC);
      m_ud  = acc && hit && bad;
      m_ret = drained;
      if (drained) m_fence = 0;
      else if (acc && hit && !bad) m_fence = 1;
      if (iss && !done && m_cnt < MAXC) m_cnt++;
      else if (done && !iss && m_cnt > 0) m_cnt--;
    end
  end

  always @(negedge clk) if (cmp_on) begin
    checks++;
    if (rdy !== !m_fence || ud !== m_ud || ret !== m_ret || err !== m_err ||
        freq_o !== freq || faddr_o !== faddr) begin
      errors++;
      $display("FAIL %s model: rdy=%b ud=%b ret=%b err=%b fill=%b/%h expected rdy=%b ud=%b ret=%b err=%b fill=%b/%h",
               phase, rdy, ud, ret, err, freq_o, faddr_o, !m_fence, m_ud, m_ret, m_err, freq, faddr);
    end
    if (ret) n_ret++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m,
                      input logic lk, input logic fe);
    bit took;
    o0 = a; o1 = b; mr = m; lock = lk; feat = fe; dec_valid = 1;
    do begin took = rdy; tick(); end while (!took);
    dec_valid = 0; lock = 0; feat = 1;
  endtask

  task automatic pulses(input int n, input logic i, input logic d);
    iss = i; done = d;
    repeat (n) tick();
    iss = 0; done = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) tick();
    rst_n = 1; cmp_on = 1;
    phase = "R1";
    chk(rdy == 1 && ud == 0 && ret == 0 && err == 0, "R1 reset state", {rdy, ud, ret, err}, 4'b1000);

    phase = "R4";
    send(8'h90, 8'h00, 8'h00, 0, 1);
    send(8'h0F, 8'hAE, 8'hE0, 0, 1);
    chk(rdy == 1 && ud == 0, "R4 reg field 4", rdy, 1);
    send(8'h0F, 8'hAE, 8'hF0, 0, 1);
    chk(rdy == 1 && ud == 0, "R4 reg field 6", rdy, 1);
    send(8'h0F, 8'hAF, 8'hE8, 0, 1);
    chk(rdy == 1 && ud == 0, "R4 second byte 0xAF", rdy, 1);

    phase = "R1";
    send(8'h0F, 8'hAE, 8'hE8, 0, 1);
    chk(rdy == 0, "R1 fence holds issue", rdy, 0);
    phase = "R6";
    tick();
    chk(ret == 1 && rdy == 1, "R6 empty fence retires", {ret, rdy}, 2'b11);
    tick();
    chk(ret == 0, "R6 retire is one cycle", ret, 0);

    phase = "R5";
    pulses(3, 1, 0);
    iss = 1; done = 1; tick(); iss = 0; done = 0;
    send(8'h0F, 8'hAE, 8'h28, 0, 1);
    phase = "R7";
    o0 = 8'h90; o1 = 8'h00; mr = 8'h00; dec_valid = 1;
    for (int k = 0; k < 5; k++) begin
      freq = k[0]; faddr = 32'h1000_0000 + k;
      tick();
      chk(rdy == 0 && ret == 0, "R7 younger held while fencing", rdy, 0);
      chk(freq_o == freq && faddr_o == faddr, "R8 fill passes during fence", int'(freq_o), int'(freq));
    end
    phase = "R5";
    pulses(3, 0, 1);
    chk(ret == 0, "R5 no retire until drained", ret, 0);
    tick();
    chk(ret == 1 && rdy == 1, "R6 retire after last completion", {ret, rdy}, 2'b11);
    tick();
    dec_valid = 0; freq = 0;

    phase = "R2";
    send(8'h0F, 8'hAE, 8'hE8, 1, 1);
    chk(ud == 1 && rdy == 1, "R2 lock raises ud", {ud, rdy}, 2'b11);
    tick();
    chk(ud == 0, "R2 ud one cycle", ud, 0);
    phase = "R3";
    send(8'h0F, 8'hAE, 8'hE8, 0, 0);
    chk(ud == 1 && rdy == 1, "R3 disabled raises ud", {ud, rdy}, 2'b11);
    tick();

    phase = "R10";
    base = n_ret;
    pulses(1, 1, 0);
    send(8'h0F, 8'hAE, 8'hE8, 0, 1);
    fork
      send(8'h0F, 8'hAE, 8'hE8, 0, 1);
      begin tick(); tick(); done = 1; tick(); done = 0; end
    join
    chk(n_ret - base == 1 && rdy == 0, "R10 second fence after first retire", n_ret - base, 1);
    tick(); tick();
    chk(n_ret - base == 2, "R10 second fence retires", n_ret - base, 2);

    phase = "R9";
    pulses(MAXC, 1, 0);
    chk(err == 0, "R9 no error at full count", err, 0);
    pulses(1, 1, 0);
    chk(err == 1, "R9 overflow flagged", err, 1);
    send(8'h0F, 8'hAE, 8'hE8, 0, 1);
    pulses(MAXC - 1, 0, 1);
    chk(ret == 0 && rdy == 0, "R9 saturated count still one left", ret, 0);
    pulses(1, 0, 1);
    tick();
    chk(ret == 1, "R9 drain after saturation", ret, 1);
    pulses(1, 0, 1);
    chk(err == 1, "R9 underflow flagged", err, 1);
    tick();
    chk(err == 0, "R9 error one cycle", err, 0);

    tick();
    cmp_on = 0; finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule